// File: doc/BRIEF.md
# Separable Sinc Interpolation Filter

A 21-tap one-dimensional convolution engine that shifts one line of samples (an image row or an image column) by applying a sub-pixel interpolation kernel. A line is first streamed into an internal line buffer. The engine then sweeps a 22-sample window across the buffer and produces two filtered samples every clock. Neighbours that fall before the first sample or past the last one are replaced by a programmable fill constant. They are not zero-padded and not clamped to the edge sample.

Two coefficient sets are kept, one for the horizontal pass and one for the vertical pass. Each start strobe chooses a set, and that set is copied into the active tap registers. A full 2D shift is done by the surrounding system: it runs one pass per row with the horizontal set, and then one pass per column of that result with the vertical set. Samples and coefficients are signed Q1.15. Sums are accumulated in 40 bits, rounded and saturated back to 16 bits.

Top module: `sinc_line_filter`

## Requirements
- R1: After reset, busy_o, out_valid_o, out_hi_valid_o and out_last_o are low. The line length is 1 and the fill value is 0.
- R2: Output sample p is the sum over taps t = 0..20 of coef[t] * x[p + 10 - t], so tap 10 is the centre. All values are signed Q1.15 (15 fractional bits). The sum is kept in a 40-bit accumulator before rounding.
- R3: When the neighbour index p + 10 - t is negative, or is equal to or greater than the line length, the fill value is used in place of the sample.
- R4: The sum is divided by 2^15 with rounding half toward positive infinity, computed as floor((acc + 2^14) / 2^15). The result is then saturated to the range -32768..32767.
- R5: Coefficients are written through the port coef_we_i, coef_set_i, coef_idx_i and coef_data_i. Set 0 is the horizontal set and set 1 is the vertical set; tap indices 0..20 are valid. On an accepted start, the set chosen by start_set_i is copied to the active taps. Coefficient writes made during a pass do not affect that pass, but they are used by the next pass.
- R6: After an accepted start, the first L samples presented with in_valid_i are stored as line samples 0..L-1, in arrival order. Idle cycles between samples are allowed. Filtering begins once sample L-1 has been taken.
- R7: Each output beat carries sample 2k on out_lo_o and sample 2k+1 on out_hi_o. Beats appear in ascending k, one on every consecutive clock, with no gaps from the first beat to the last.
- R8: out_last_o is high on the final beat only. For an odd L the final beat has out_hi_valid_o low. Every other beat has out_hi_valid_o high.
- R9: busy_o rises on the cycle after an accepted start and stays high until the final beat has been presented. It falls on the next cycle. A start strobe while busy_o is high is ignored.
- R10: Line length and fill value are written with len_we_i/len_data_i and fill_we_i/fill_data_i. Writes made while busy_o is high are ignored. A length of 0 is stored as 1, and a length above 1024 is stored as 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_set_i | input | 1 | Coefficient set to write (0 horizontal, 1 vertical) |
| coef_idx_i | input | 5 | Tap index 0..20 |
| coef_data_i | input | 16 | Coefficient value, Q1.15 |
| fill_we_i | input | 1 | Fill value write strobe |
| fill_data_i | input | 16 | Fill value for out-of-line neighbours |
| len_we_i | input | 1 | Line length write strobe |
| len_data_i | input | 11 | Line length, clamped to 1..1024 |
| start_i | input | 1 | Start a pass |
| start_set_i | input | 1 | Coefficient set used by the pass |
| in_valid_i | input | 1 | Line sample valid |
| in_data_i | input | 16 | Line sample, Q1.15 |
| busy_o | output | 1 | Pass in progress |
| out_valid_o | output | 1 | Output beat valid |
| out_hi_valid_o | output | 1 | Second sample of the beat valid |
| out_last_o | output | 1 | Final beat of the line |
| out_lo_o | output | 16 | Filtered sample 2k |
| out_hi_o | output | 16 | Filtered sample 2k+1 |

## Verification
The bound checker checks the output framing on every cycle:
- the high-half valid and the last marker only appear with a valid beat;
- every beat before the last carries two samples;
- beats follow one another without gaps until the last;
- busy holds through a pass and drops right after the final beat.

The arithmetic can only be shown by the bench's scenarios, each compared against an independent model of the sum. This covers the tap orientation, the fill substitution at both line ends, rounding and saturation, the choice of set and the snapshot of the taps at start, and the ignoring of start and configuration writes during a pass.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  localparam int NTAPS   = 21;
  localparam int DW      = 16;
  localparam int FRAC    = 15;
  localparam int ACCW    = 40;
  localparam int MAX_LEN = 1024;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} fstate_e;
endpackage

// File: rtl/sinc_coef_bank.sv
module sinc_coef_bank #(
  parameter int DW    = sinc_pkg::DW,
  parameter int NTAPS = sinc_pkg::NTAPS,
  localparam int IW   = $clog2(NTAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_set_i,
  input  logic [IW-1:0]        wr_idx_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 snap_i,
  input  logic                 snap_set_i,
  output logic signed [DW-1:0] act_o [NTAPS]
);
  logic signed [DW-1:0] bank_q [2][NTAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NTAPS; t++) begin
        bank_q[0][t] <= '0;
        bank_q[1][t] <= '0;
        act_o[t]     <= '0;
      end
    end else begin
      for (int t = 0; t < NTAPS; t++) begin
        if (wr_en_i && wr_idx_i == IW'(t)) bank_q[wr_set_i][t] <= wr_data_i;
        // active copy taken at start; later bank writes wait for next pass
        if (snap_i) act_o[t] <= bank_q[snap_set_i][t];
      end
    end
  end
endmodule

// File: rtl/sinc_line_buf.sv
module sinc_line_buf #(
  parameter int DW    = sinc_pkg::DW,
  parameter int DEPTH = sinc_pkg::MAX_LEN,
  parameter int IDXW  = $clog2(DEPTH) + 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [IDXW-1:0]      rd_idx_i,
  input  logic [LW-1:0]        len_i,
  input  logic signed [DW-1:0] fill_i,
  output logic signed [DW-1:0] rd0_o,
  output logic signed [DW-1:0] rd1_o
);
  logic [DW-1:0]   mem [DEPTH];
  logic [IDXW-1:0] idx1;
  logic            in0, in1;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_comb begin
    idx1  = rd_idx_i + IDXW'(1);
    in0   = rd_idx_i < IDXW'(len_i);
    in1   = idx1 < IDXW'(len_i);
    rd0_o = in0 ? $signed(mem[rd_idx_i[AW-1:0]]) : fill_i;
    rd1_o = in1 ? $signed(mem[idx1[AW-1:0]]) : fill_i;
  end
endmodule

// File: rtl/sinc_tap_window.sv
module sinc_tap_window #(
  parameter int DW = sinc_pkg::DW,
  parameter int N  = sinc_pkg::NTAPS + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] fill_i,
  input  logic signed [DW-1:0] in0_i,
  input  logic signed [DW-1:0] in1_i,
  output logic signed [DW-1:0] win_o [N]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) win_o[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < N; i++) win_o[i] <= fill_i;
    end else if (shift_i) begin
      for (int i = 0; i < N - 2; i++) win_o[i] <= win_o[i+2];
      win_o[N-2] <= in0_i;
      win_o[N-1] <= in1_i;
    end
  end
endmodule

// File: rtl/sinc_dot.sv
module sinc_dot #(
  parameter int DW    = sinc_pkg::DW,
  parameter int NTAPS = sinc_pkg::NTAPS,
  parameter int FRAC  = sinc_pkg::FRAC,
  parameter int ACCW  = sinc_pkg::ACCW
) (
  input  logic signed [DW-1:0] coef_i [NTAPS],
  input  logic signed [DW-1:0] win_i  [NTAPS],
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [ACCW-1:0] MAXV = ACCW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] MINV = -MAXV - ACCW'(1);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);

  logic signed [2*DW-1:0] prod;
  logic signed [ACCW-1:0] acc, sh;

  always_comb begin
    acc = '0;
    // window slot i holds sample p-c+i, so tap t pairs with slot NTAPS-1-t
    for (int t = 0; t < NTAPS; t++) begin
      prod = coef_i[t] * win_i[NTAPS-1-t];
      acc  = acc + ACCW'(prod);
    end
    sh = (acc + HALF) >>> FRAC;
    if (sh > MAXV)      y_o = MAXV[DW-1:0];
    else if (sh < MINV) y_o = MINV[DW-1:0];
    else                y_o = sh[DW-1:0];
  end
endmodule

// File: rtl/sinc_line_filter.sv
module sinc_line_filter #(
  parameter int DW      = sinc_pkg::DW,
  parameter int NTAPS   = sinc_pkg::NTAPS,
  parameter int FRAC    = sinc_pkg::FRAC,
  parameter int ACCW    = sinc_pkg::ACCW,
  parameter int MAX_LEN = sinc_pkg::MAX_LEN,
  localparam int IW     = $clog2(NTAPS),
  localparam int AW     = $clog2(MAX_LEN),
  localparam int LW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          coef_we_i,
  input  logic          coef_set_i,
  input  logic [IW-1:0] coef_idx_i,
  input  logic [DW-1:0] coef_data_i,
  input  logic          fill_we_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic          len_we_i,
  input  logic [LW-1:0] len_data_i,
  input  logic          start_i,
  input  logic          start_set_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          busy_o,
  output logic          out_valid_o,
  output logic          out_hi_valid_o,
  output logic          out_last_o,
  output logic [DW-1:0] out_lo_o,
  output logic [DW-1:0] out_hi_o
);
  import sinc_pkg::*;

  localparam int PW   = LW + 2;
  localparam int CTR  = (NTAPS - 1) / 2;
  localparam int NWIN = NTAPS + 1;
  localparam int LEAD = CTR + 2;
  localparam logic signed [PW-1:0] WIN_START = PW'(-LEAD);

  fstate_e              state_q;
  logic [AW-1:0]        wr_ptr_q;
  logic signed [PW-1:0] win_p_q;
  logic [LW-1:0]        len_q, len_clamp;
  logic signed [DW-1:0] fill_q;
  logic                 ov_q, ohv_q, olast_q;
  logic [DW-1:0]        olo_q, ohi_q;

  logic                 start_ok, load_last, emit, hi_ok, last_beat;
  logic [PW-1:0]        p_u, rd_idx;
  logic signed [DW-1:0] rd0, rd1;
  logic signed [DW-1:0] coef_act [NTAPS];
  logic signed [DW-1:0] win      [NWIN];
  logic signed [DW-1:0] slice    [2][NTAPS];
  logic signed [DW-1:0] y        [2];

  assign busy_o    = (state_q != ST_IDLE) || ov_q;
  assign start_ok  = start_i && !busy_o;
  assign load_last = (state_q == ST_LOAD) && in_valid_i &&
                     ({1'b0, wr_ptr_q} == len_q - LW'(1));
  // window centre p = win_p_q; outputs start once p reaches 0
  assign emit      = (state_q == ST_RUN) && !win_p_q[PW-1];
  assign p_u       = win_p_q;
  assign hi_ok     = (p_u + PW'(1)) < PW'(len_q);
  assign last_beat = (p_u + PW'(2)) >= PW'(len_q);
  assign rd_idx    = win_p_q + PW'(LEAD);

  always_comb begin
    len_clamp = len_data_i;
    if (len_data_i == '0)                 len_clamp = LW'(1);
    else if (len_data_i > LW'(MAX_LEN))   len_clamp = LW'(MAX_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_ptr_q <= '0;
      win_p_q  <= '0;
      len_q    <= LW'(1);
      fill_q   <= '0;
      ov_q     <= 1'b0;
      ohv_q    <= 1'b0;
      olast_q  <= 1'b0;
      olo_q    <= '0;
      ohi_q    <= '0;
    end else begin
      if (len_we_i && !busy_o)  len_q  <= len_clamp;
      if (fill_we_i && !busy_o) fill_q <= fill_data_i;
      ov_q    <= emit;
      ohv_q   <= emit && hi_ok;
      olast_q <= emit && last_beat;
      if (emit) begin
        olo_q <= y[0];
        ohi_q <= y[1];
      end
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q  <= ST_LOAD;
          wr_ptr_q <= '0;
        end
        ST_LOAD: if (in_valid_i) begin
          if (load_last) begin
            state_q <= ST_RUN;
            win_p_q <= WIN_START;
          end else begin
            wr_ptr_q <= wr_ptr_q + AW'(1);
          end
        end
        ST_RUN: begin
          win_p_q <= win_p_q + PW'(2);
          if (emit && last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sinc_coef_bank #(.DW(DW), .NTAPS(NTAPS)) u_coef (
    .clk_i, .rst_ni,
    .wr_en_i(coef_we_i), .wr_set_i(coef_set_i), .wr_idx_i(coef_idx_i),
    .wr_data_i(coef_data_i), .snap_i(start_ok), .snap_set_i(start_set_i),
    .act_o(coef_act)
  );

  sinc_line_buf #(.DW(DW), .DEPTH(MAX_LEN), .IDXW(PW)) u_buf (
    .clk_i,
    .wr_en_i(state_q == ST_LOAD && in_valid_i), .wr_addr_i(wr_ptr_q),
    .wr_data_i(in_data_i), .rd_idx_i(rd_idx), .len_i(len_q), .fill_i(fill_q),
    .rd0_o(rd0), .rd1_o(rd1)
  );

  sinc_tap_window #(.DW(DW), .N(NWIN)) u_win (
    .clk_i, .rst_ni, .clr_i(load_last), .shift_i(state_q == ST_RUN),
    .fill_i(fill_q), .in0_i(rd0), .in1_i(rd1), .win_o(win)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      assign slice[g][i] = win[i+g];
    end
    sinc_dot #(.DW(DW), .NTAPS(NTAPS), .FRAC(FRAC), .ACCW(ACCW)) u_dot (
      .coef_i(coef_act), .win_i(slice[g]), .y_o(y[g])
    );
  end

  assign out_valid_o    = ov_q;
  assign out_hi_valid_o = ohv_q;
  assign out_last_o     = olast_q;
  assign out_lo_o       = olo_q;
  assign out_hi_o       = ohi_q;
endmodule

// File: rtl/sinc_line_filter_chk.sv
module sinc_line_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic out_valid_o,
  input logic out_hi_valid_o,
  input logic out_last_o
);
  p_hi_with_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hi_valid_o |-> out_valid_o);
  p_last_with_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  p_full_beat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> out_hi_valid_o);
  p_no_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o);
  p_valid_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o);
  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(out_valid_o && out_last_o)) |=> busy_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |=> !busy_o);
endmodule

bind sinc_line_filter sinc_line_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .out_valid_o(out_valid_o), .out_hi_valid_o(out_hi_valid_o), .out_last_o(out_last_o)
);

// File: tb/tb_sinc_line_filter.sv
module tb_sinc_line_filter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        coef_we_i = 0, coef_set_i = 0, fill_we_i = 0, len_we_i = 0;
  logic        start_i = 0, start_set_i = 0, in_valid_i = 0;
  logic [4:0]  coef_idx_i = '0;
  logic [15:0] coef_data_i = '0, fill_data_i = '0, in_data_i = '0;
  logic [10:0] len_data_i = '0;
  logic        busy_o, out_valid_o, out_hi_valid_o, out_last_o;
  logic [15:0] out_lo_o, out_hi_o;

  always #10 clk = ~clk;

  sinc_line_filter dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .coef_we_i(coef_we_i), .coef_set_i(coef_set_i), .coef_idx_i(coef_idx_i),
    .coef_data_i(coef_data_i), .fill_we_i(fill_we_i), .fill_data_i(fill_data_i),
    .len_we_i(len_we_i), .len_data_i(len_data_i), .start_i(start_i),
    .start_set_i(start_set_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .busy_o(busy_o), .out_valid_o(out_valid_o), .out_hi_valid_o(out_hi_valid_o),
    .out_last_o(out_last_o), .out_lo_o(out_lo_o), .out_hi_o(out_hi_o)
  );

  int tests = 0, fails = 0, cyc = 0, cap_n = 0;
  int cap_lo [512], cap_hi [512], cap_cyc [512];
  bit cap_hv [512], cap_last [512];
  int xs [1024];
  int cf [2][21];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (out_valid_o && cap_n < 512) begin
      cap_lo[cap_n]   = $signed(out_lo_o);
      cap_hi[cap_n]   = $signed(out_hi_o);
      cap_hv[cap_n]   = out_hi_valid_o;
      cap_last[cap_n] = out_last_o;
      cap_cyc[cap_n]  = cyc;
      cap_n++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model(int p, int set, int n, int fill);
    longint acc = 0;
    longint r;
    for (int t = 0; t < 21; t++) begin
      int idx = p + 10 - t;
      int s = (idx < 0 || idx >= n) ? fill : xs[idx];
      acc += longint'(cf[set][t]) * s;
    end
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic load_set(int set);
    for (int t = 0; t < 21; t++) begin
      @(negedge clk);
      coef_we_i = 1; coef_set_i = set[0]; coef_idx_i = t[4:0];
      coef_data_i = cf[set][t][15:0];
    end
    @(negedge clk);
    coef_we_i = 0;
  endtask

  task automatic set_cfg(int len, int fill);
    @(negedge clk);
    len_we_i = 1; len_data_i = len[10:0];
    fill_we_i = 1; fill_data_i = fill[15:0];
    @(negedge clk);
    len_we_i = 0; fill_we_i = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(!busy_o, "R9", "pass completes", busy_o, 0);
  endtask

  task automatic run_pass(int set, int n, int gap);
    cap_n = 0;
    @(negedge clk);
    start_i = 1; start_set_i = set[0];
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        in_valid_i = 0;
        @(negedge clk);
      end
      in_valid_i = 1; in_data_i = xs[i][15:0];
      @(negedge clk);
    end
    in_valid_i = 0;
    wait_idle();
  endtask

  task automatic check_pass(string req, int set, int n, int fill);
    int np = (n + 1) / 2;
    check(cap_n == np, req, "beat count", cap_n, np);
    for (int k = 0; k < cap_n && k < np; k++) begin
      int e0 = model(2*k, set, n, fill);
      check(cap_lo[k] == e0, req, $sformatf("lo sample %0d", 2*k), cap_lo[k], e0);
      if (2*k + 1 < n) begin
        int e1 = model(2*k + 1, set, n, fill);
        check(cap_hv[k], "R8", $sformatf("hi valid beat %0d", k), cap_hv[k], 1);
        check(cap_hi[k] == e1, req, $sformatf("hi sample %0d", 2*k+1), cap_hi[k], e1);
      end else begin
        check(!cap_hv[k], "R8", "odd tail hi valid", cap_hv[k], 0);
      end
      check(cap_last[k] == (k == np - 1), "R8", $sformatf("last on beat %0d", k),
            cap_last[k], k == np - 1);
      if (k > 0)
        check(cap_cyc[k] == cap_cyc[k-1] + 1, "R7", $sformatf("beat %0d spacing", k),
              cap_cyc[k] - cap_cyc[k-1], 1);
    end
  endtask

  // R1
  task automatic t_reset();
    check(!busy_o && !out_valid_o && !out_hi_valid_o && !out_last_o, "R1",
          "idle outputs", {busy_o, out_valid_o, out_hi_valid_o, out_last_o}, 0);
  endtask

  // R2, R6, R7: asymmetric taps, samples with gaps
  task automatic t_kernel();
    for (int t = 0; t < 21; t++) cf[0][t] = (t - 10) * 700 + t * 13 + (t == 10 ? 9000 : 0);
    load_set(0);
    for (int i = 0; i < 16; i++) xs[i] = i * 100 - 700;
    set_cfg(16, 0);
    run_pass(0, 16, 1);
    check_pass("R2", 0, 16, 0);
  endtask

  // R3, R8: nonzero fill, odd length
  task automatic t_fill();
    for (int i = 0; i < 9; i++) xs[i] = ((i * 7919) % 2001) - 1000;
    set_cfg(9, 1234);
    run_pass(0, 9, 0);
    check_pass("R3", 0, 9, 1234);
  endtask

  // R5: same line through both sets
  task automatic t_sets();
    for (int t = 0; t < 21; t++) cf[1][t] = 2000 - t * 150;
    load_set(1);
    for (int i = 0; i < 10; i++) xs[i] = (i % 3) * 900 - 500 + i;
    set_cfg(10, -77);
    run_pass(1, 10, 0);
    check_pass("R5", 1, 10, -77);
    run_pass(0, 10, 0);
    check_pass("R5", 0, 10, -77);
  endtask

  // R9, R10, R5: start, config and tap writes during a pass
  task automatic t_busy();
    int seen;
    int newc = 20000;
    for (int i = 0; i < 12; i++) xs[i] = i * 211 - 1100;
    set_cfg(12, 50);
    fork
      run_pass(0, 12, 0);
      begin
        repeat (4) @(negedge clk);
        start_i = 1; start_set_i = 1;
        len_we_i = 1; len_data_i = 11'd3;
        fill_we_i = 1; fill_data_i = 16'd99;
        coef_we_i = 1; coef_set_i = 0; coef_idx_i = 5'd10; coef_data_i = newc[15:0];
        @(negedge clk);
        start_i = 0; len_we_i = 0; fill_we_i = 0; coef_we_i = 0;
      end
    join
    check_pass("R9", 0, 12, 50);
    seen = cap_n;
    repeat (10) @(negedge clk);
    check(cap_n == seen && !busy_o, "R9", "no pass from ignored start", cap_n, seen);
    cf[0][10] = newc;
    run_pass(0, 12, 0);
    check_pass("R10", 0, 12, 50);
  endtask

  // R4: rounding half up and saturation
  task automatic t_round();
    for (int t = 0; t < 21; t++) cf[1][t] = (t == 10) ? 16384 : 0;
    load_set(1);
    xs[0] = 3; xs[1] = -3; xs[2] = 5; xs[3] = -5;
    set_cfg(4, 0);
    run_pass(1, 4, 0);
    check_pass("R4", 1, 4, 0);
    check(cap_lo[0] == 2 && cap_hi[0] == -1, "R4", "1.5 and -1.5", cap_hi[0], -1);
    for (int t = 0; t < 21; t++) cf[1][t] = 16384;
    load_set(1);
    for (int i = 0; i < 6; i++) xs[i] = (i < 3) ? 30000 : -30000;
    set_cfg(6, 30000);
    run_pass(1, 6, 0);
    check_pass("R4", 1, 6, 30000);
    check(cap_lo[0] == 32767, "R4", "positive saturation", cap_lo[0], 32767);
    set_cfg(6, -30000);
    run_pass(1, 6, 0);
    check(cap_hi[2] == -32768, "R4", "negative saturation", cap_hi[2], -32768);
  endtask

  // R8, R10: length 1, zero clamp, full length with high clamp
  task automatic t_lengths();
    xs[0] = 4000;
    set_cfg(1, 10);
    run_pass(0, 1, 0);
    check_pass("R8", 0, 1, 10);
    set_cfg(0, 10);
    run_pass(0, 1, 0);
    check_pass("R10", 0, 1, 10);
    for (int i = 0; i < 1024; i++) xs[i] = ((i * 37) % 4001) - 2000;
    set_cfg(1500, -3);
    run_pass(0, 1024, 0);
    check_pass("R10", 0, 1024, -3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_kernel();
    t_fill();
    t_sets();
    t_busy();
    t_round();
    t_lengths();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule